// File: doc/BRIEF.md
# Configurable Tag Propagation Unit

This block sits in the execute stage of a pipelined 32-bit processor that carries a one-bit security tag beside every register value and every memory byte. For each instruction it computes the tag the destination register receives, and for stores the tags written back to memory. The inputs are the source operand tags, the destination's previous tag and the instruction class. The rule applied is not fixed. Each instruction class has its own two-bit policy field in a configuration register that software writes once at startup through the control/status register path.

Seven classes each own a policy field: arithmetic, branch, jump, shift, comparison, logical and load/store. A policy either keeps the old destination tag, requires both sources to be tagged, accepts either source being tagged, or clears the tag. Memory accesses have an extra enable bit. When it is off, loaded values and stored bytes are never tagged. When it is on, the load/store policy combines the tag of the memory data with the tag of the address register. Register x0 always carries a clean tag.

The block is combinational from its operand inputs to its outputs. The only state is the configuration register.

Top module: `tag_prop_unit`

## Requirements
- R1: After reset the configuration register is all zeros. Every non-memory class then keeps the old destination tag, and loads produce tag 0.
- R2: A configuration write with `cfg_we_i` high is captured at the rising clock edge and governs outputs from then on. Without a write the configuration never changes.
- R3: Policy fields sit at these bit positions: arithmetic [1:0], branch [3:2], jump [5:4], shift [7:6], comparison [9:8], logical [11:10], load/store [13:12]. The load/store enable is bit 16. Class codes on `cls_i` are arithmetic 0, branch 1, jump 2, shift 3, comparison 4, logical 5, load/store 6 and unused 7.
- R4: Policy 00 passes `old_rd_tag_i` to `rd_tag_o` unchanged.
- R5: Policy 01 gives tag 1 only when both source tags are 1.
- R6: Policy 10 gives tag 1 when at least one source tag is 1.
- R7: Policy 11 gives tag 0.
- R8: When `has_rs2_i` is 0, the rs2 tag is treated as 0 whatever `rs2_tag_i` holds.
- R9: When `rd_is_x0_i` is 1, `rd_tag_o` is 0 regardless of class and policy.
- R10: With load/store enable 0, a load gives `rd_tag_o` 0 and a store drives `mem_tag_o` all zeros.
- R11: With load/store enable 1, a load applies the load/store policy. Its first input is the OR of `mem_tag_i`, its second input is `rs1_tag_i` (the address tag), and its old value is `old_rd_tag_i`.
- R12: With load/store enable 1, a store applies the load/store policy to the data tag `rs2_tag_i` and the address tag `rs1_tag_i`. Its old value is the OR of `mem_tag_i`, and the result is replicated to every bit of `mem_tag_o`. A store passes `old_rd_tag_i` to `rd_tag_o`. Every non-store passes `mem_tag_i` to `mem_tag_o`.
- R13: Configuration bits [15:14] have no effect, and class code 7 always gives `rd_tag_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 17 | Configuration write data |
| cls_i | input | 3 | Instruction class code |
| is_store_i | input | 1 | Load/store class instruction is a store |
| rs1_tag_i | input | 1 | Tag of first source register |
| rs2_tag_i | input | 1 | Tag of second source register |
| has_rs2_i | input | 1 | Instruction reads a second source register |
| old_rd_tag_i | input | 1 | Current tag of the destination register |
| rd_is_x0_i | input | 1 | Destination register is x0 |
| mem_tag_i | input | 4 | Byte tags of the accessed memory word |
| rd_tag_o | output | 1 | New destination register tag |
| mem_tag_o | output | 4 | Byte tags to write to memory |

## Verification
On every cycle the assertions check three things: a clean x0 destination, the zero tags forced while load/store tagging is disabled, and stored byte tags that are always all equal. They also check that the configuration register only changes on a write. Only the bench's scenarios can show the truth table of each policy, the field each class decodes, and how memory tags combine with the address tag. The same holds for the one-cycle delay before a write takes effect and for the spare bits and unused class code having no effect.

// File: rtl/tprop_pkg.sv
package tprop_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int CFG_W      = 17;
    localparam int MODE_W     = 2;
    localparam int LS_EN_BIT  = 16;

    typedef enum logic [2:0] {
        CLS_ARITH  = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_JUMP   = 3'd2,
        CLS_SHIFT  = 3'd3,
        CLS_CMP    = 3'd4,
        CLS_LOGIC  = 3'd5,
        CLS_LDST   = 3'd6,
        CLS_NONE   = 3'd7
    } tp_class_e;

    typedef enum logic [1:0] {
        PM_KEEP   = 2'b00,
        PM_BOTH   = 2'b01,
        PM_EITHER = 2'b10,
        PM_CLEAR  = 2'b11
    } tp_mode_e;

    function automatic logic tp_apply(tp_mode_e m, logic a, logic b, logic old);
        logic r;
        unique case (m)
            PM_KEEP:   r = old;
            PM_BOTH:   r = a & b;
            PM_EITHER: r = a | b;
            PM_CLEAR:  r = 1'b0;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tprop_cfg_reg.sv
module tprop_cfg_reg
    import tprop_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cfg_q_o,
    output tp_mode_e     modes_o [NUM_FIELDS],
    output logic         ls_en_o
);

    logic [W-1:0] cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign modes_o[g] = tp_mode_e'(cfg_q[MODE_W*g +: MODE_W]);
    end

    assign ls_en_o = cfg_q[LS_EN_BIT];
    assign cfg_q_o = cfg_q;

endmodule

// File: rtl/tprop_core.sv
module tprop_core
    import tprop_pkg::*;
(
    input  tp_class_e cls_i,
    input  tp_mode_e  modes_i [NUM_FIELDS],
    input  logic      rs1_tag_i,
    input  logic      rs2_tag_i,
    input  logic      has_rs2_i,
    input  logic      old_tag_i,
    output tp_mode_e  mode_sel_o,
    output logic      tag_o
);

    logic rs2_eff;

    always_comb begin
        rs2_eff    = has_rs2_i & rs2_tag_i;
        mode_sel_o = PM_CLEAR;
        if (cls_i != CLS_NONE) begin
            mode_sel_o = modes_i[int'(cls_i)];
        end
        tag_o = tp_apply(mode_sel_o, rs1_tag_i, rs2_eff, old_tag_i);
    end

endmodule

// File: rtl/tprop_ldst.sv
module tprop_ldst
    import tprop_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  tp_mode_e          mode_i,
    input  logic              ls_en_i,
    input  logic              addr_tag_i,
    input  logic              data_tag_i,
    input  logic              old_rd_tag_i,
    input  logic [NBYTES-1:0] mem_tag_i,
    output logic              ld_tag_o,
    output logic [NBYTES-1:0] st_tag_o
);

    logic mem_any;
    logic st_bit;

    always_comb begin
        mem_any  = |mem_tag_i;
        ld_tag_o = 1'b0;
        st_bit   = 1'b0;
        if (ls_en_i) begin
            ld_tag_o = tp_apply(mode_i, mem_any, addr_tag_i, old_rd_tag_i);
            st_bit   = tp_apply(mode_i, data_tag_i, addr_tag_i, mem_any);
        end
        st_tag_o = {NBYTES{st_bit}};
    end

endmodule

// File: rtl/tag_prop_unit.sv
module tag_prop_unit
    import tprop_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic [2:0]        cls_i,
    input  logic              is_store_i,
    input  logic              rs1_tag_i,
    input  logic              rs2_tag_i,
    input  logic              has_rs2_i,
    input  logic              old_rd_tag_i,
    input  logic              rd_is_x0_i,
    input  logic [NBYTES-1:0] mem_tag_i,
    output logic              rd_tag_o,
    output logic [NBYTES-1:0] mem_tag_o
);

    tp_class_e          cls;
    tp_mode_e           modes [NUM_FIELDS];
    tp_mode_e           mode_sel;
    logic [CFG_W-1:0]   cfg_q;
    logic               ls_en;
    logic               gen_tag;
    logic               ld_tag;
    logic [NBYTES-1:0]  st_tag;

    assign cls = tp_class_e'(cls_i);

    tprop_cfg_reg #(.W(CFG_W)) cfg_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_q_o (cfg_q),
        .modes_o (modes),
        .ls_en_o (ls_en)
    );

    tprop_core core_i (
        .cls_i      (cls),
        .modes_i    (modes),
        .rs1_tag_i  (rs1_tag_i),
        .rs2_tag_i  (rs2_tag_i),
        .has_rs2_i  (has_rs2_i),
        .old_tag_i  (old_rd_tag_i),
        .mode_sel_o (mode_sel),
        .tag_o      (gen_tag)
    );

    tprop_ldst #(.NBYTES(NBYTES)) ldst_i (
        .mode_i       (modes[int'(CLS_LDST)]),
        .ls_en_i      (ls_en),
        .addr_tag_i   (rs1_tag_i),
        .data_tag_i   (rs2_tag_i),
        .old_rd_tag_i (old_rd_tag_i),
        .mem_tag_i    (mem_tag_i),
        .ld_tag_o     (ld_tag),
        .st_tag_o     (st_tag)
    );

    always_comb begin
        rd_tag_o  = gen_tag;
        mem_tag_o = mem_tag_i;
        if (cls == CLS_LDST) begin
            if (is_store_i) begin
                rd_tag_o  = old_rd_tag_i;
                mem_tag_o = st_tag;
            end else begin
                rd_tag_o  = ld_tag;
            end
        end
        if (rd_is_x0_i) begin
            rd_tag_o = 1'b0;
        end
    end

    // R9: x0 destination is always clean
    a_r9_x0_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_is_x0_i |-> !rd_tag_o);

    // R10: disabled load/store tagging gives clean loads and stores
    a_r10_ls_off_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls == CLS_LDST && !is_store_i && !cfg_q[LS_EN_BIT]) |-> !rd_tag_o);
    a_r10_ls_off_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls == CLS_LDST && is_store_i && !cfg_q[LS_EN_BIT]) |-> (mem_tag_o == '0));

    // R12: stored byte tags are uniform
    a_r12_store_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls == CLS_LDST && is_store_i) |->
        ($countones(mem_tag_o) == 0 || $countones(mem_tag_o) == NBYTES));

    // R2: configuration holds without a write
    a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_we_i |=> $stable(cfg_q));

    // R7: clear policy on a non-memory class never tags rd
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls != CLS_LDST && mode_sel == PM_CLEAR) |-> !rd_tag_o);

endmodule

// File: tb/tag_prop_unit_tb_top.sv
module tag_prop_unit_tb_top;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [16:0]   cfg_wdata = '0;
    logic [2:0]    cls = '0;
    logic          is_store = 1'b0;
    logic          rs1 = 1'b0;
    logic          rs2 = 1'b0;
    logic          has_rs2 = 1'b1;
    logic          old_rd = 1'b0;
    logic          x0 = 1'b0;
    logic [NB-1:0] mem_in = '0;
    logic          rd_tag;
    logic [NB-1:0] mem_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tag_prop_unit #(.NBYTES(NB)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_wdata_i  (cfg_wdata),
        .cls_i        (cls),
        .is_store_i   (is_store),
        .rs1_tag_i    (rs1),
        .rs2_tag_i    (rs2),
        .has_rs2_i    (has_rs2),
        .old_rd_tag_i (old_rd),
        .rd_is_x0_i   (x0),
        .mem_tag_i    (mem_in),
        .rd_tag_o     (rd_tag),
        .mem_tag_o    (mem_out)
    );

    function automatic logic [16:0] fld(int idx, logic [1:0] m);
        logic [16:0] w = '0;
        w[2*idx +: 2] = m;
        return w;
    endfunction

    task automatic chk(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [16:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(logic [2:0] c, logic st, logic a, logic b, logic hb,
                         logic od, logic z, logic [NB-1:0] m);
        cls = c; is_store = st; rs1 = a; rs2 = b; has_rs2 = hb;
        old_rd = od; x0 = z; mem_in = m;
        #1;
    endtask

    task automatic t_reset();
        drive(3'd0, 0, 0, 0, 1, 1, 0, 4'h0);
        chk("R1 keep old=1", {3'b0, rd_tag}, 4'h1);
        drive(3'd5, 0, 1, 1, 1, 0, 0, 4'h0);
        chk("R1 R4 keep old=0", {3'b0, rd_tag}, 4'h0);
        drive(3'd6, 0, 1, 0, 1, 1, 0, 4'hF);
        chk("R1 load clean", {3'b0, rd_tag}, 4'h0);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = fld(0, 2'b11);
        drive(3'd0, 0, 1, 1, 1, 1, 0, 4'h0);
        chk("R2 before edge", {3'b0, rd_tag}, 4'h1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R2 after edge", {3'b0, rd_tag}, 4'h0);
        @(negedge clk);
        #1;
        chk("R2 held", {3'b0, rd_tag}, 4'h0);
    endtask

    task automatic t_policies();
        write_cfg(fld(0, 2'b01));
        for (int i = 0; i < 4; i++) begin
            drive(3'd0, 0, i[0], i[1], 1, 1, 0, 4'h0);
            chk("R5 both", {3'b0, rd_tag}, {3'b0, i[0] & i[1]});
        end
        write_cfg(fld(0, 2'b10));
        for (int i = 0; i < 4; i++) begin
            drive(3'd0, 0, i[0], i[1], 1, 0, 0, 4'h0);
            chk("R6 either", {3'b0, rd_tag}, {3'b0, i[0] | i[1]});
        end
        write_cfg(fld(0, 2'b11));
        drive(3'd0, 0, 1, 1, 1, 1, 0, 4'h0);
        chk("R7 clear", {3'b0, rd_tag}, 4'h0);
        write_cfg(fld(0, 2'b00));
        drive(3'd0, 0, 1, 1, 1, 0, 0, 4'h0);
        chk("R4 keep ignores sources", {3'b0, rd_tag}, 4'h0);
    endtask

    task automatic t_layout();
        for (int k = 0; k < 6; k++) begin
            logic [16:0] w = '0;
            for (int j = 0; j < 6; j++) w |= fld(j, (j == k) ? 2'b10 : 2'b11);
            write_cfg(w);
            for (int c = 0; c < 6; c++) begin
                drive(3'(c), 0, 1, 0, 1, 1, 0, 4'h0);
                chk($sformatf("R3 field %0d class %0d", k, c), {3'b0, rd_tag},
                    {3'b0, (c == k)});
            end
        end
    endtask

    task automatic t_single_and_x0();
        write_cfg(fld(5, 2'b01) | fld(0, 2'b10));
        drive(3'd5, 0, 1, 1, 0, 0, 0, 4'h0);
        chk("R8 missing rs2", {3'b0, rd_tag}, 4'h0);
        drive(3'd5, 0, 1, 1, 1, 0, 0, 4'h0);
        chk("R8 present rs2", {3'b0, rd_tag}, 4'h1);
        drive(3'd0, 0, 1, 1, 1, 1, 1, 4'h0);
        chk("R9 x0", {3'b0, rd_tag}, 4'h0);
        write_cfg(fld(0, 2'b10) | 17'h0C000);
        drive(3'd0, 0, 1, 0, 1, 0, 0, 4'h0);
        chk("R13 spare bits", {3'b0, rd_tag}, 4'h1);
        drive(3'd0, 0, 0, 0, 1, 1, 0, 4'h0);
        chk("R13 spare bits zero", {3'b0, rd_tag}, 4'h0);
        drive(3'd7, 0, 1, 1, 1, 1, 0, 4'h0);
        chk("R13 class 7", {3'b0, rd_tag}, 4'h0);
        drive(3'd0, 0, 0, 0, 1, 0, 0, 4'hA);
        chk("R12 non-store mem pass", mem_out, 4'hA);
    endtask

    task automatic t_ldst();
        write_cfg(fld(6, 2'b10));
        drive(3'd6, 1, 0, 1, 1, 0, 0, 4'h5);
        chk("R10 store disabled", mem_out, 4'h0);
        drive(3'd6, 0, 1, 0, 1, 1, 0, 4'h2);
        chk("R10 load disabled", {3'b0, rd_tag}, 4'h0);
        write_cfg(fld(6, 2'b10) | 17'h10000);
        drive(3'd6, 0, 0, 0, 1, 0, 0, 4'b0100);
        chk("R11 load mem tag", {3'b0, rd_tag}, 4'h1);
        drive(3'd6, 0, 0, 0, 1, 1, 0, 4'h0);
        chk("R11 load clean", {3'b0, rd_tag}, 4'h0);
        drive(3'd6, 1, 0, 1, 1, 0, 0, 4'h0);
        chk("R12 store either", mem_out, 4'hF);
        chk("R12 store rd keeps old", {3'b0, rd_tag}, 4'h0);
        write_cfg(fld(6, 2'b01) | 17'h10000);
        drive(3'd6, 0, 1, 0, 1, 0, 0, 4'b0001);
        chk("R11 load both", {3'b0, rd_tag}, 4'h1);
        drive(3'd6, 0, 0, 0, 1, 0, 0, 4'b0001);
        chk("R11 load both addr clean", {3'b0, rd_tag}, 4'h0);
        drive(3'd6, 1, 0, 1, 1, 1, 0, 4'h0);
        chk("R12 store both", mem_out, 4'h0);
        chk("R12 store rd old", {3'b0, rd_tag}, 4'h1);
        write_cfg(fld(6, 2'b00) | 17'h10000);
        drive(3'd6, 1, 1, 1, 1, 0, 0, 4'b0010);
        chk("R12 store keep", mem_out, 4'hF);
        drive(3'd6, 1, 1, 1, 1, 0, 0, 4'h0);
        chk("R12 store keep clean", mem_out, 4'h0);
        drive(3'd6, 0, 1, 0, 1, 1, 0, 4'h0);
        chk("R11 load keep", {3'b0, rd_tag}, 4'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_timing();
        t_policies();
        t_layout();
        t_single_and_x0();
        t_ldst();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule